// File: doc/BRIEF.md
# Scanline Sprite Selector

This block decides, once per scanline, which sprites a renderer has to draw on that line. It holds the vertical coordinate of every sprite in a small on-chip table that is loaded through a byte-wide write port. The layout of that port is one four-byte record per sprite. After a start pulse, it checks the sprites one per clock cycle in ascending index order. It places each sprite that covers the requested line into one of a fixed number of slots, together with the row inside the sprite that the line falls on.

The sprite height comes from two mode inputs: a size bit (8 or 16 lines) and a zoom bit, which doubles the height and halves the row step. When a covering sprite is found after every slot is already taken, the block raises a sticky overflow flag, records that sprite's index and stops the scan. A sticky collision flag is set by a pulse from the pixel renderer. Both flags and the recorded index return to zero on a clear pulse, which is issued when the status is read.

Top module: `sprite_line_eval`

## Requirements
- R1: A write with address bits [1:0] equal to 0 stores `wr_data` as the vertical position of sprite `wr_addr/4`. Writes with address bits [1:0] equal to 1, 2 or 3 have no effect on any selection.
- R2: A sprite covers line L when (L − Y) mod 256 < H. Y is the sprite's vertical position. H is 8 when `size16`=0 and 16 when `size16`=1, and H is doubled when `zoom`=1.
- R3: Covering sprites are taken in ascending index order into slots 0, 1, 2, … up to SLOTS (4). `sel_count` gives how many were taken, and `sel_valid` has exactly its low `sel_count` bits set. Slot s occupies `sel_index[s*IDX_W +: IDX_W]` and `sel_row[s*4 +: 4]`. Unused slots read index 0 and row 0.
- R4: The row of a taken sprite is (L − Y) mod 256 when `zoom`=0, and that value shifted right by one when `zoom`=1.
- R5: A covering sprite found while all SLOTS slots are full sets `ovf_flag` and loads its index into `reject_idx`. The scan ends there, and `done` is high k+2 cycles after the start cycle, where k is that sprite's index.
- R6: Without an overflow, all NUM_SPRITES sprites are checked. `busy` is high during the scan, and `done` is a one-cycle pulse that is high NUM_SPRITES+1 cycles after the start cycle. `start` raises `busy` on the next cycle.
- R7: A `coll_pulse` sets `coll_flag` on the next cycle. The flag stays set without further pulses.
- R8: `clear` returns `ovf_flag`, `coll_flag` and `reject_idx` to 0 on the next cycle. A flag-setting event in the same cycle as `clear` takes priority and leaves its flag set.
- R9: After reset, `busy`, `done`, `sel_count`, `sel_valid`, `ovf_flag`, `coll_flag` and `reject_idx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Byte address into the sprite records |
| wr_data | input | 8 | Byte to write |
| line | input | 8 | Scanline to evaluate |
| size16 | input | 1 | 0: 8-line sprites, 1: 16-line sprites |
| zoom | input | 1 | 1: sprites doubled |
| start | input | 1 | Begin evaluating `line` |
| coll_pulse | input | 1 | Pixel overlap seen by the renderer |
| clear | input | 1 | Status read, drops the flags |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| sel_count | output | CNT_W | Number of slots filled |
| sel_valid | output | SLOTS | Slot occupied flags |
| sel_index | output | SLOTS*IDX_W | Sprite index per slot |
| sel_row | output | SLOTS*4 | Row offset per slot |
| ovf_flag | output | 1 | Too many sprites on a line |
| coll_flag | output | 1 | Sprite overlap seen |
| reject_idx | output | IDX_W | Index of the first sprite that did not fit |

## Verification
The bench builds the block with NUM_SPRITES=12 and SLOTS=4. This gives a full scan of only 13 cycles, and it lets the bench give every table entry a chosen position, including the highest index, so that the last sprite is actually taken. With 12 sprites, the rejected index fits in a four-bit nibble. The chosen positions produce wraparound past line 255, exact height boundaries, every size and zoom combination, and an overflow partway through the table, where the cycle count shows that the scan stopped early.

// File: rtl/sprite_eval_pkg.sv
package sprite_eval_pkg;

    localparam int ROW_W = 4;

    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic             hit;
        logic [ROW_W-1:0] row;
    } line_match_t;

    function automatic logic [7:0] sprite_height(input logic size16, input logic zoom);
        logic [7:0] base;
        base = size16 ? 8'd16 : 8'd8;
        return zoom ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/sprite_attr_ram.sv
module sprite_attr_ram #(
    parameter int NUM_SPRITES = 64,
    parameter int ADDR_W      = 8,
    parameter int IDX_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_y
);
    logic [7:0] ypos_q [NUM_SPRITES];
    logic [ADDR_W-3:0] wr_sprite;

    assign wr_sprite = wr_addr[ADDR_W-1:2];

    // only byte 0 of each record feeds the evaluation
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SPRITES; i++) ypos_q[i] <= 8'd0;
        end else if (wr_en && wr_addr[1:0] == 2'd0
                     && int'(wr_sprite) < NUM_SPRITES) begin
            ypos_q[wr_sprite] <= wr_data;
        end
    end

    assign rd_y = (int'(rd_idx) < NUM_SPRITES) ? ypos_q[rd_idx] : 8'd0;

endmodule

// File: rtl/sprite_line_match.sv
module sprite_line_match
    import sprite_eval_pkg::*;
(
    input  logic [7:0]  line,
    input  logic [7:0]  ypos,
    input  logic        size16,
    input  logic        zoom,
    output line_match_t match
);
    logic [7:0] delta;
    logic [7:0] height;

    assign delta  = line - ypos;
    assign height = sprite_height(size16, zoom);

    always_comb begin
        match.hit = delta < height;
        match.row = zoom ? delta[ROW_W:1] : delta[ROW_W-1:0];
    end

endmodule

// File: rtl/sprite_slot_bank.sv
module sprite_slot_bank
    import sprite_eval_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDX_W = 6,
    parameter int CNT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   load,
    input  logic [CNT_W-1:0]       load_slot,
    input  logic [IDX_W-1:0]       load_idx,
    input  logic [ROW_W-1:0]       load_row,
    output logic [SLOTS-1:0]       sel_valid,
    output logic [SLOTS*IDX_W-1:0] sel_index,
    output logic [SLOTS*ROW_W-1:0] sel_row
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic             v_q;
        logic [IDX_W-1:0] idx_q;
        logic [ROW_W-1:0] row_q;

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                v_q   <= 1'b0;
                idx_q <= '0;
                row_q <= '0;
            end else if (load && load_slot == CNT_W'(s)) begin
                v_q   <= 1'b1;
                idx_q <= load_idx;
                row_q <= load_row;
            end
        end

        assign sel_valid[s]                 = v_q;
        assign sel_index[s*IDX_W +: IDX_W]  = idx_q;
        assign sel_row[s*ROW_W +: ROW_W]    = row_q;
    end

endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sprite_eval_pkg::*;
#(
    parameter int NUM_SPRITES = 64,
    parameter int SLOTS       = 4,
    localparam int IDX_W      = (NUM_SPRITES > 1) ? $clog2(NUM_SPRITES) : 1,
    localparam int ADDR_W     = IDX_W + 2,
    localparam int CNT_W      = $clog2(SLOTS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [7:0]               line,
    input  logic                     size16,
    input  logic                     zoom,
    input  logic                     start,
    input  logic                     coll_pulse,
    input  logic                     clear,
    output logic                     busy,
    output logic                     done,
    output logic [CNT_W-1:0]         sel_count,
    output logic [SLOTS-1:0]         sel_valid,
    output logic [SLOTS*IDX_W-1:0]   sel_index,
    output logic [SLOTS*ROW_W-1:0]   sel_row,
    output logic                     ovf_flag,
    output logic                     coll_flag,
    output logic [IDX_W-1:0]         reject_idx
);
    scan_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] count_q;
    logic             done_q;
    logic [7:0]       line_q;
    logic             size_q, zoom_q;
    logic [7:0]       cur_y;
    line_match_t      match;
    logic             step, slots_full, take, reject, last;

    sprite_attr_ram #(
        .NUM_SPRITES(NUM_SPRITES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_idx(idx_q), .rd_y(cur_y)
    );

    sprite_line_match u_match (
        .line(line_q), .ypos(cur_y), .size16(size_q), .zoom(zoom_q), .match(match)
    );

    assign step       = (state_q == SCAN_RUN) && !start;
    assign slots_full = count_q == CNT_W'(SLOTS);
    assign take       = step && match.hit && !slots_full;
    assign reject     = step && match.hit && slots_full;
    assign last       = idx_q == IDX_W'(NUM_SPRITES - 1);

    sprite_slot_bank #(
        .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_slots (
        .clk(clk), .rst(rst), .flush(start), .load(take),
        .load_slot(count_q), .load_idx(idx_q), .load_row(match.row),
        .sel_valid(sel_valid), .sel_index(sel_index), .sel_row(sel_row)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
            line_q  <= '0;
            size_q  <= 1'b0;
            zoom_q  <= 1'b0;
        end else if (start) begin
            state_q <= SCAN_RUN;
            idx_q   <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
            line_q  <= line;
            size_q  <= size16;
            zoom_q  <= zoom;
        end else begin
            done_q <= 1'b0;
            if (step) begin
                if (take) count_q <= count_q + 1'b1;
                if (reject || last) begin
                    state_q <= SCAN_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // sticky status: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag   <= 1'b0;
            coll_flag  <= 1'b0;
            reject_idx <= '0;
        end else begin
            if (reject) begin
                ovf_flag   <= 1'b1;
                reject_idx <= idx_q;
            end else if (clear) begin
                ovf_flag   <= 1'b0;
                reject_idx <= '0;
            end
            if (coll_pulse)  coll_flag <= 1'b1;
            else if (clear)  coll_flag <= 1'b0;
        end
    end

    assign busy      = state_q == SCAN_RUN;
    assign done      = done_q;
    assign sel_count = count_q;

    assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    assert_fill_matches_count_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(sel_valid) == int'(sel_count));
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> sel_count == CNT_W'(SLOTS));
    assert_coll_set_R7: assert property (@(posedge clk) disable iff (rst)
        coll_pulse |=> coll_flag);
    assert_coll_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && !coll_pulse) |=> !coll_flag);

endmodule

// File: tb/sprite_line_eval_tb.sv
module sprite_line_eval_tb;
    localparam int N     = 12;
    localparam int SL    = 4;
    localparam int IW    = 4;
    localparam int AW    = 6;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] line = '0;
    logic size16 = 1'b0, zoom = 1'b0, start = 1'b0, coll_pulse = 1'b0, clear = 1'b0;
    logic busy, done, ovf_flag, coll_flag;
    logic [CW-1:0] sel_count;
    logic [SL-1:0] sel_valid;
    logic [SL*IW-1:0] sel_index;
    logic [SL*4-1:0] sel_row;
    logic [IW-1:0] reject_idx;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sprite_line_eval #(.NUM_SPRITES(N), .SLOTS(SL)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .line(line), .size16(size16), .zoom(zoom), .start(start),
        .coll_pulse(coll_pulse), .clear(clear), .busy(busy), .done(done),
        .sel_count(sel_count), .sel_valid(sel_valid), .sel_index(sel_index),
        .sel_row(sel_row), .ovf_flag(ovf_flag), .coll_flag(coll_flag),
        .reject_idx(reject_idx)
    );

    // vertical positions of sprites 0..11
    localparam logic [7:0] YTAB [N] = '{8'd10, 8'd12, 8'd20, 8'd100, 8'd104, 8'd106,
                                        8'd108, 8'd110, 8'd250, 8'd200, 8'd60, 8'd60};

    // {line, size16, zoom, count, idx{s3,s2,s1,s0}, row{s3,s2,s1,s0}, ovf, reject}
    localparam int VW = 8 + 1 + 1 + 3 + 16 + 16 + 1 + 4;
    localparam logic [VW-1:0] VEC [8] = '{
        {8'd14,  1'b0, 1'b0, 3'd2, 16'h0010, 16'h0024, 1'b0, 4'd0},
        {8'd112, 1'b0, 1'b0, 3'd3, 16'h0765, 16'h0246, 1'b0, 4'd0},
        {8'd112, 1'b1, 1'b0, 3'd4, 16'h6543, 16'h468C, 1'b1, 4'd7},
        {8'd2,   1'b1, 1'b0, 3'd1, 16'h0008, 16'h0008, 1'b0, 4'd0},
        {8'd2,   1'b0, 1'b0, 3'd0, 16'h0000, 16'h0000, 1'b0, 4'd0},
        {8'd25,  1'b0, 1'b1, 3'd3, 16'h0210, 16'h0267, 1'b0, 4'd0},
        {8'd230, 1'b1, 1'b1, 3'd1, 16'h0009, 16'h000F, 1'b0, 4'd0},
        {8'd60,  1'b0, 1'b0, 3'd2, 16'h00BA, 16'h0000, 1'b0, 4'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic run_scan(input logic [7:0] l, input logic s, input logic z,
                            output int cyc);
        @(negedge clk);
        line = l; size16 = s; zoom = z; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_vec(input int v, input string tag);
        logic [VW-1:0] e;
        int cyc, exp_cyc;
        e = VEC[v];
        pulse_clear();
        run_scan(e[VW-1 -: 8], e[VW-9], e[VW-10], cyc);
        exp_cyc = e[4] ? int'(e[3:0]) + 2 : N + 1;
        chk(cyc == exp_cyc, {tag, " R5/R6 done timing"}, cyc, exp_cyc);
        chk(sel_count == e[VW-11 -: 3], {tag, " R2 count"}, sel_count, e[VW-11 -: 3]);
        chk(sel_index == e[36:21], {tag, " R3 indices"}, sel_index, e[36:21]);
        chk(sel_row == e[20:5], {tag, " R4 rows"}, sel_row, e[20:5]);
        chk(ovf_flag == e[4], {tag, " R5 overflow"}, ovf_flag, e[4]);
        chk(reject_idx == e[3:0], {tag, " R5 reject index"}, reject_idx, e[3:0]);
        chk($countones(sel_valid) == int'(e[VW-11 -: 3]) && sel_valid[0] == (e[VW-11 -: 3] != 0),
            {tag, " R3 valid"}, sel_valid, e[VW-11 -: 3]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done, "R9 busy/done", {busy, done}, 0);
        chk(sel_count == 0 && sel_valid == 0, "R9 slots", sel_count, 0);
        chk(!ovf_flag && !coll_flag && reject_idx == 0, "R9 flags",
            {ovf_flag, coll_flag, reject_idx}, 0);

        // R1 load table, junk in unused record bytes
        for (int i = 0; i < N; i++) begin
            write_byte(4*i, YTAB[i]);
            write_byte(4*i + 1, 8'd14);
            write_byte(4*i + 2, 8'hA5);
            write_byte(4*i + 3, 8'd112);
        end

        for (int v = 0; v < 8; v++) run_vec(v, $sformatf("vec%0d", v));

        // R6 busy right after start
        @(negedge clk); line = 8'd14; size16 = 0; zoom = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy, "R6 busy after start", busy, 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done, "R6 done is one cycle", done, 0);

        // R1 writes to offsets 1..3 ignored
        write_byte(4*0 + 2, 8'd200);
        write_byte(4*3 + 1, 8'd14);
        write_byte(4*9 + 3, 8'd10);
        run_vec(0, "R1 ignore");

        // R1 offset 0 rewrite moves sprite 10 onto line 14
        write_byte(4*10, 8'd13);
        run_scan(8'd14, 1'b0, 1'b0, cyc);
        chk(sel_count == 3 && sel_index[11:8] == 4'd10 && sel_row[11:8] == 4'd1,
            "R1 rewrite", {sel_count, sel_index}, 32'h3_0A10);
        write_byte(4*10, 8'd60);

        // R5 sticky overflow persists across a later clean scan
        run_scan(8'd112, 1'b1, 1'b0, cyc);
        run_scan(8'd14, 1'b0, 1'b0, cyc);
        chk(ovf_flag && reject_idx == 4'd7, "R5 sticky", {ovf_flag, reject_idx}, 5'h17);

        // R7 collision
        @(negedge clk); coll_pulse = 1'b1;
        @(negedge clk); coll_pulse = 1'b0;
        chk(coll_flag, "R7 set", coll_flag, 1);
        repeat (3) @(negedge clk);
        chk(coll_flag, "R7 held", coll_flag, 1);

        // R8 clear together with collision keeps it set, clear alone drops all
        @(negedge clk); clear = 1'b1; coll_pulse = 1'b1;
        @(negedge clk); clear = 1'b0; coll_pulse = 1'b0;
        chk(coll_flag, "R8 event beats clear", coll_flag, 1);
        chk(!ovf_flag && reject_idx == 0, "R8 overflow cleared", {ovf_flag, reject_idx}, 0);
        pulse_clear();
        chk(!coll_flag, "R8 collision cleared", coll_flag, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule